// File: doc/BRIEF.md
# Per-Bank Activate Spacing Guard

This block watches the command stream going to one DRAM bank and says, cycle by cycle, whether a new ACTIVATE may go to that bank, and whether a REFRESH that involves the bank may go. Four spacing rules apply at once:

- activate to next activate or refresh;
- activate to next activate when a write with auto-close shut the page, measured from the original activate;
- page-hit read to next activate;
- refresh to next activate or refresh.

Each rule owns a down-counter. The counter loads when its command arrives, and a reload can only lengthen the remaining wait, never shorten it.

The four minimum gaps are cycle counts on input ports, and the scheduler around the block drives them. The scheduler issues a command only while the matching ready flag is high. If a command arrives while its flag is low, a sticky violation flag is raised and stays high until reset. Typical programmed values are a 16-cycle activate gap, a 19-cycle write-close gap, a 12-cycle page-hit gap and a 34-cycle refresh gap.

Top module: `bank_act_guard`

## Requirements
- R1: An activate issued in cycle t keeps `act_ready_o` and `ref_ready_o` low until cycle t+`gap_act_i`. The activate-gap rule clears from that cycle on.
- R2: A write with auto-close issued in cycle w, with the latest activate in cycle a ≤ w, keeps `act_ready_o` low until cycle a+`gap_wrclose_i`. An activate in the same cycle as the write counts as a=w. A write with no activate in the last 255 cycles adds no wait.
- R3: A page-hit read issued in cycle t keeps `act_ready_o` low until cycle t+`gap_hit_i`.
- R4: A refresh issued in cycle t keeps `act_ready_o` and `ref_ready_o` low until cycle t+`gap_ref_i`.
- R5: A later command of the same rule that implies an earlier release than the one already pending does not shorten the pending wait. A command that implies a later release extends it.
- R6: `act_ready_o` is high only when all four rules are clear. `ref_ready_o` depends only on the activate-gap rule and the refresh-gap rule, so reads and auto-close writes never lower it.
- R7: An activate while `act_ready_o` is low, or a refresh while `ref_ready_o` is low, sets `violation_o` in the next cycle. Once set, `violation_o` stays high until reset.
- R8: In the first cycle after reset, `act_ready_o` and `ref_ready_o` are high and `violation_o` is low.
- R9: A gap value of 0 or 1 adds no wait beyond the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 1 | ACTIVATE issued to the bank this cycle |
| rd_hit_i | input | 1 | Page-hit read issued this cycle |
| wr_close_i | input | 1 | Write with auto-close issued this cycle |
| ref_i | input | 1 | REFRESH involving the bank issued this cycle |
| gap_act_i | input | 8 | Minimum cycles from activate to next activate or refresh |
| gap_wrclose_i | input | 8 | Minimum cycles from activate to next activate when the page was closed by a write |
| gap_hit_i | input | 8 | Minimum cycles from page-hit read to next activate |
| gap_ref_i | input | 8 | Minimum cycles from refresh to next activate or refresh |
| act_ready_o | output | 1 | An activate may issue this cycle |
| ref_ready_o | output | 1 | A refresh may issue this cycle |
| violation_o | output | 1 | Sticky: a command was issued while its ready flag was low |

## Verification
The write-close rule measures from the activate, so its load depends on the activate age. The most delicate coincidence is therefore an activate and an auto-close write in the same cycle, where the age must be taken as zero rather than the stale age of the previous activate. The random stimulus also lets a read, a write and a refresh land together, and lets commands land while an earlier wait is still running, which exercises the keep-the-larger reload. A bench model holds one absolute release cycle for each rule and takes the maximum on every command. Each cycle it compares both ready flags against that model, so a wrong winner shows up as a flag that rises too early or too late.

// File: rtl/bag_pkg.sv
package bag_pkg;
  parameter int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  // Value to load so the counter reaches zero exactly `gap` cycles after the command.
  function automatic cnt_t gap_load(input cnt_t gap);
    return (gap == '0) ? '0 : cnt_t'(gap - cnt_t'(1));
  endfunction

  function automatic cnt_t sat_dec(input cnt_t c);
    return (c == '0) ? '0 : cnt_t'(c - cnt_t'(1));
  endfunction

  // Remaining part of a gap that started `age` cycles ago.
  function automatic cnt_t rest_load(input cnt_t gap, input cnt_t age);
    return (gap > age) ? cnt_t'(gap - age - cnt_t'(1)) : '0;
  endfunction

  function automatic cnt_t cnt_max(input cnt_t a, input cnt_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bag_spacing_ctr.sv
module bag_spacing_ctr
  import bag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  cnt_t ld_val,
  output cnt_t cnt,
  output logic idle
);
  cnt_t nxt;

  always_comb begin
    nxt = sat_dec(cnt);
    if (ld) nxt = cnt_max(ld_val, nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/bag_act_age.sv
module bag_act_age
  import bag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output cnt_t age
);
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '1;
    else if (act)        age <= cnt_t'(1);
    else if (age != '1)  age <= cnt_t'(age + cnt_t'(1));
  end
endmodule

// File: rtl/bank_act_guard.sv
module bank_act_guard
  import bag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_i,
  input  logic                 rd_hit_i,
  input  logic                 wr_close_i,
  input  logic                 ref_i,
  input  logic [CNT_W-1:0]     gap_act_i,
  input  logic [CNT_W-1:0]     gap_wrclose_i,
  input  logic [CNT_W-1:0]     gap_hit_i,
  input  logic [CNT_W-1:0]     gap_ref_i,
  output logic                 act_ready_o,
  output logic                 ref_ready_o,
  output logic                 violation_o
);
  localparam int NR      = 4;
  localparam int I_ACT   = 0;
  localparam int I_WRC   = 1;
  localparam int I_HIT   = 2;
  localparam int I_REF   = 3;

  cnt_t            age;
  cnt_t            age_eff;
  logic [NR-1:0]   ld;
  cnt_t [NR-1:0]   ld_val;
  cnt_t [NR-1:0]   cnt;
  logic [NR-1:0]   idle;
  logic            act_bad;
  logic            ref_bad;
  logic            viol_q;

  bag_act_age u_age (.clk(clk), .rst_n(rst_n), .act(act_i), .age(age));

  assign age_eff = act_i ? '0 : age;

  assign ld[I_ACT]     = act_i;
  assign ld[I_WRC]     = wr_close_i;
  assign ld[I_HIT]     = rd_hit_i;
  assign ld[I_REF]     = ref_i;
  assign ld_val[I_ACT] = gap_load(gap_act_i);
  assign ld_val[I_WRC] = rest_load(gap_wrclose_i, age_eff);
  assign ld_val[I_HIT] = gap_load(gap_hit_i);
  assign ld_val[I_REF] = gap_load(gap_ref_i);

  for (genvar g = 0; g < NR; g++) begin : g_rule
    bag_spacing_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(ld[g]), .ld_val(ld_val[g]),
      .cnt(cnt[g]), .idle(idle[g])
    );
  end

  assign act_ready_o = &idle;
  assign ref_ready_o = idle[I_ACT] & idle[I_REF];

  assign act_bad = act_i & ~act_ready_o;
  assign ref_bad = ref_i & ~ref_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n)                  viol_q <= 1'b0;
    else if (act_bad | ref_bad)  viol_q <= 1'b1;
  end

  assign violation_o = viol_q;
endmodule

// File: rtl/bag_checker.sv
module bag_checker
  import bag_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic act_i,
  input logic rd_hit_i,
  input logic ref_i,
  input cnt_t gap_act_i,
  input cnt_t gap_hit_i,
  input cnt_t gap_ref_i,
  input logic act_bad,
  input logic ref_bad,
  input logic act_ready_o,
  input logic ref_ready_o,
  input logic violation_o
);
  p_act_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && gap_act_i > cnt_t'(1)) |=> (!act_ready_o && !ref_ready_o));

  p_hit_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_i && gap_hit_i > cnt_t'(1)) |=> !act_ready_o);

  p_ref_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && gap_ref_i > cnt_t'(1)) |=> (!act_ready_o && !ref_ready_o));

  p_ready_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_ready_o |-> ref_ready_o);

  p_viol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bad || ref_bad) |=> violation_o);

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |=> violation_o);
endmodule

bind bank_act_guard bag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .act_i(act_i), .rd_hit_i(rd_hit_i), .ref_i(ref_i),
  .gap_act_i(gap_act_i), .gap_hit_i(gap_hit_i), .gap_ref_i(gap_ref_i),
  .act_bad(act_bad), .ref_bad(ref_bad),
  .act_ready_o(act_ready_o), .ref_ready_o(ref_ready_o), .violation_o(violation_o)
);

// File: tb/sim_bank_act_guard.sv
`timescale 1ns/1ps
module sim_bank_act_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0, rdh = 1'b0, wrc = 1'b0, rf = 1'b0;
  logic [7:0] g_act = 8'd16, g_wrc = 8'd19, g_hit = 8'd12, g_ref = 8'd34;
  logic act_rdy, ref_rdy, viol;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  longint now = 0;
  longint t_act = 0, t_wrc = 0, t_hit = 0, t_ref = 0;
  longint last_act = -100000;
  bit exp_viol = 1'b0;

  always #2 clk = ~clk;

  bank_act_guard u0 (
    .clk(clk), .rst_n(rst_n), .act_i(act), .rd_hit_i(rdh), .wr_close_i(wrc), .ref_i(rf),
    .gap_act_i(g_act), .gap_wrclose_i(g_wrc), .gap_hit_i(g_hit), .gap_ref_i(g_ref),
    .act_ready_o(act_rdy), .ref_ready_o(ref_rdy), .violation_o(viol)
  );

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction
  // Release of a gap: never earlier than the cycle after the command (R9).
  function automatic longint rel(input longint t, input int gap);
    return t + ((gap < 1) ? 1 : gap);
  endfunction
  function automatic bit m_act_rdy();
    return now >= lmax(lmax(t_act, t_wrc), lmax(t_hit, t_ref));
  endfunction
  function automatic bit m_ref_rdy();
    return now >= lmax(t_act, t_ref);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, now, got, exp);
    end
  endtask

  // Compare outputs with the model for the current cycle.
  task automatic chk_all(input string req);
    chk(req, act_rdy, m_act_rdy());
    chk("R6", ref_rdy, m_ref_rdy());
    chk("R7", viol, exp_viol);
  endtask

  // Apply commands for this cycle, update the model, advance one cycle.
  task automatic step(input bit a, input bit r, input bit w, input bit f);
    act = a; rdh = r; wrc = w; rf = f;
    if ((a && !m_act_rdy()) || (f && !m_ref_rdy())) exp_viol = 1'b1;
    if (a) begin
      t_act = lmax(t_act, rel(now, g_act));
      last_act = now;
    end
    if (w && (now - last_act) <= 255)
      t_wrc = lmax(t_wrc, lmax(last_act + g_wrc, now + 1));
    else if (w)
      t_wrc = lmax(t_wrc, now + 1);
    if (r) t_hit = lmax(t_hit, rel(now, g_hit));
    if (f) t_ref = lmax(t_ref, rel(now, g_ref));
    @(negedge clk);
    act = 1'b0; rdh = 1'b0; wrc = 1'b0; rf = 1'b0;
    now++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: state right after reset
    chk("R8", act_rdy, 1'b1);
    chk("R8", ref_rdy, 1'b1);
    chk("R8", viol, 1'b0);

    // R1 directed: activate gap 16, ready again exactly 16 cycles later
    g_act = 8'd16;
    step(1, 0, 0, 0);
    for (int k = 1; k <= 17; k++) begin chk_all("R1"); step(0, 0, 0, 0); end

    // R2 directed: activate and auto-close write in the same cycle
    g_wrc = 8'd19;
    step(1, 0, 1, 0);
    for (int k = 1; k <= 20; k++) begin chk_all("R2"); step(0, 0, 0, 0); end
    // R2: write 5 cycles after activate, measured from the activate
    step(1, 0, 0, 0);
    repeat (4) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    for (int k = 1; k <= 20; k++) begin chk_all("R2"); step(0, 0, 0, 0); end

    // R3 / R6: page-hit read blocks activate but not refresh
    g_hit = 8'd12;
    step(0, 1, 0, 0);
    for (int k = 1; k <= 13; k++) begin chk_all("R3"); step(0, 0, 0, 0); end

    // R4: refresh gap 34
    g_ref = 8'd34;
    step(0, 0, 0, 1);
    for (int k = 1; k <= 35; k++) begin chk_all("R4"); step(0, 0, 0, 0); end

    // R5: long read then short read; the long wait governs
    g_hit = 8'd20;
    step(0, 1, 0, 0);
    g_hit = 8'd3;
    repeat (2) step(0, 1, 0, 0);
    for (int k = 1; k <= 20; k++) begin chk_all("R5"); step(0, 0, 0, 0); end

    // R9: gaps of 0 and 1
    g_act = 8'd0; g_ref = 8'd1;
    step(1, 0, 0, 1);
    chk_all("R9");
    step(1, 0, 0, 0);
    chk_all("R9");

    // Random phase, commands issued only when the model allows them
    for (int i = 0; i < 4000; i++) begin
      bit a, r, w, f;
      if ($urandom % 24 == 0) g_act = 8'($urandom % 41);
      if ($urandom % 24 == 0) g_wrc = 8'($urandom % 41);
      if ($urandom % 24 == 0) g_hit = 8'($urandom % 41);
      if ($urandom % 24 == 0) g_ref = 8'($urandom % 41);
      chk_all("R5");
      a = m_act_rdy() && ($urandom % 3 == 0);
      f = m_ref_rdy() && ($urandom % 10 == 0);
      r = ($urandom % 5 == 0);
      w = ($urandom % 7 == 0);
      step(a, r, w, f);
    end

    // R7: activate while blocked sets the sticky flag
    g_act = 8'd8;
    repeat (45) step(0, 0, 0, 0);
    chk_all("R7");
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk_all("R7");
    repeat (12) step(0, 0, 0, 0);
    chk_all("R7");
    chk("R7", viol, 1'b1);

    finish_run();
  end
endmodule